// File: doc/BRIEF.md
# Processor Bus Cycle Sequencer

This block is the bus-master end of a processor-style bus. Internal logic hands it one read or write request at a time, and the block turns each request into a machine cycle. The external bus has separate address and data lines plus a control group. Memory and I/O-port transfers share the address and data lines. The slaves tell them apart only by which of four active-low strobes goes low: memory read, memory write, I/O read or I/O write.

Every machine cycle lasts four clocks:

- T1 drives the address and raises the address-valid flag.
- T2 and T3 hold the selected strobe low.
- T4 releases the strobe.

Read data is taken from the data lines at the instant the read strobe rises, which is the clock edge that ends T3. The result is handed back with a one-clock done pulse. When no request is waiting, the sequencer runs null cycles and leaves every strobe high.

Top module: `bus_cycle_seq`

## Requirements
- R1: After reset, all four strobes are high, `addr_vld_o`, `data_oe_o` and `done_o` are low, and `req_ready_o` is high.
- R2: A request is accepted only in a clock where `req_ready_o` is high and `req_valid_i` is high. T1 follows in the next clock. `req_ready_o` stays low through T1 to T4.
- R3: In T1, `addr_o` equals the accepted address and `addr_vld_o` is high. `addr_vld_o` is low in T2 to T4. `addr_o` holds its value from T1 through T4.
- R4: The request kind is encoded as {`req_io_i`, `req_write_i`]: 00 is memory read, 01 is memory write, 10 is I/O read and 11 is I/O write. In T2 and T3, only the strobe that matches the kind is low.
- R5: At most one strobe is low at any time. All strobes are high in T1, in T4 and in idle clocks.
- R6: On a write, `data_oe_o` is high and `data_o` equals the request data during T2 and T3. `data_oe_o` is low at all other times.
- R7: On a read, `rdata_o` takes the value that `data_i` holds at the clock edge ending T3. Changes to `data_i` after that edge have no effect on it.
- R8: `done_o` is high for exactly the one clock after T4 and is low otherwise. Write cycles leave `rdata_o` unchanged.
- R9: While no request is presented, the bus stays in null cycles: strobes high, `addr_vld_o` low, `req_ready_o` high.
- R10: With `req_valid_i` held high, successive T1 states are exactly five clocks apart.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| req_valid_i | input | 1 | Request present |
| req_ready_o | output | 1 | Sequencer idle, request will be taken |
| req_write_i | input | 1 | 1 = write, 0 = read |
| req_io_i | input | 1 | 1 = I/O port space, 0 = memory |
| req_addr_i | input | 20 | Request address |
| req_wdata_i | input | 8 | Write data |
| done_o | output | 1 | One-clock completion pulse |
| rdata_o | output | 8 | Data captured by the last read |
| addr_o | output | 20 | Bus address |
| addr_vld_o | output | 1 | Address-valid flag, high in T1 |
| data_o | output | 8 | Bus data driven by the master |
| data_oe_o | output | 1 | Master drives data lines when high |
| data_i | input | 8 | Bus data returned by a slave |
| mem_rd_no | output | 1 | Memory read strobe, active low |
| mem_wr_no | output | 1 | Memory write strobe, active low |
| io_rd_no | output | 1 | I/O read strobe, active low |
| io_wr_no | output | 1 | I/O write strobe, active low |

## Verification
The hardest case to create from the ports is a read where the data lines change right after the strobe rises. A design that samples one edge late, or keeps sampling through T4, looks correct whenever the slave holds its data steady. The bench model therefore drives the expected byte only during T2 and T3, and puts its complement on the lines from T4 onward. All four kinds are swept over a set of computed address and data patterns. A back-to-back run with the request held valid exposes any extra or missing clock between cycles.

// File: rtl/bus_seq_pkg.sv
package bus_seq_pkg;
  typedef enum logic [2:0] {ST_IDLE, ST_T1, ST_T2, ST_T3, ST_T4} tstate_e;
  localparam int unsigned N_STRB = 4;
  // kind = {io, write}
  localparam logic [1:0] K_MEM_RD = 2'd0;
  localparam logic [1:0] K_MEM_WR = 2'd1;
  localparam logic [1:0] K_IO_RD  = 2'd2;
  localparam logic [1:0] K_IO_WR  = 2'd3;
endpackage

// File: rtl/bus_seq_tstate.sv
module bus_seq_tstate
  import bus_seq_pkg::*;
(
  input  logic     clk_i,
  input  logic     rst_ni,
  input  logic     start_i,
  output tstate_e  state_o,
  output logic     ready_o,
  output logic     done_o
);
  tstate_e state_q, state_d;
  logic    done_q;

  always_comb begin
    state_d = state_q;
    unique case (state_q)
      ST_IDLE: if (start_i) state_d = ST_T1;
      ST_T1:   state_d = ST_T2;
      ST_T2:   state_d = ST_T3;
      ST_T3:   state_d = ST_T4;
      ST_T4:   state_d = ST_IDLE;
      default: state_d = ST_IDLE;
    endcase
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      state_q <= ST_IDLE;
      done_q  <= 1'b0;
    end else begin
      state_q <= state_d;
      done_q  <= (state_q == ST_T4);
    end
  end

  assign state_o = state_q;
  assign ready_o = (state_q == ST_IDLE);
  assign done_o  = done_q;

  // R2
  start_to_t1_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (ready_o && start_i) |=> (state_q == ST_T1));
  // R8
  done_single_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    done_o |=> !done_o);
endmodule

// File: rtl/bus_seq_strobe.sv
module bus_seq_strobe
  import bus_seq_pkg::*;
(
  input  logic              clk_i,
  input  logic              rst_ni,
  input  tstate_e           state_i,
  input  logic [1:0]        kind_i,
  output logic [N_STRB-1:0] strb_no
);
  logic active;
  assign active = (state_i == ST_T2) || (state_i == ST_T3);

  for (genvar g = 0; g < N_STRB; g++) begin : g_strb
    assign strb_no[g] = !(active && (kind_i == 2'(g)));
  end

  // R5
  strb_onehot_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $onehot0(~strb_no));
  // R4
  strb_hold_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (state_i == ST_T2) |=> $stable(strb_no));
endmodule

// File: rtl/bus_seq_dpath.sv
module bus_seq_dpath
  import bus_seq_pkg::*;
#(
  parameter int unsigned ADDR_W = 20,
  parameter int unsigned DATA_W = 8
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              load_i,
  input  logic [ADDR_W-1:0] req_addr_i,
  input  logic [DATA_W-1:0] req_wdata_i,
  input  logic [1:0]        req_kind_i,
  input  tstate_e           state_i,
  input  logic [DATA_W-1:0] data_i,
  output logic [1:0]        kind_o,
  output logic [ADDR_W-1:0] addr_o,
  output logic [DATA_W-1:0] data_o,
  output logic              data_oe_o,
  output logic [DATA_W-1:0] rdata_o
);
  logic [ADDR_W-1:0] addr_q;
  logic [DATA_W-1:0] wdata_q, rdata_q;
  logic [1:0]        kind_q;
  logic              is_wr;

  assign is_wr = kind_q[0];

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      addr_q  <= '0;
      wdata_q <= '0;
      kind_q  <= K_MEM_RD;
      rdata_q <= '0;
    end else begin
      if (load_i) begin
        addr_q  <= req_addr_i;
        wdata_q <= req_wdata_i;
        kind_q  <= req_kind_i;
      end
      // read strobe rises on this edge
      if (state_i == ST_T3 && !is_wr) rdata_q <= data_i;
    end
  end

  assign kind_o    = kind_q;
  assign addr_o    = addr_q;
  assign data_oe_o = is_wr && (state_i == ST_T2 || state_i == ST_T3);
  assign data_o    = wdata_q;
  assign rdata_o   = rdata_q;

  // R3
  addr_hold_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (state_i == ST_T2 || state_i == ST_T3 || state_i == ST_T4) |-> $stable(addr_o));
  // R7
  rdata_when_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (state_i != ST_T3) |=> $stable(rdata_o));
endmodule

// File: rtl/bus_cycle_seq.sv
module bus_cycle_seq
  import bus_seq_pkg::*;
#(
  parameter int unsigned ADDR_W = 20,
  parameter int unsigned DATA_W = 8
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              req_valid_i,
  output logic              req_ready_o,
  input  logic              req_write_i,
  input  logic              req_io_i,
  input  logic [ADDR_W-1:0] req_addr_i,
  input  logic [DATA_W-1:0] req_wdata_i,
  output logic              done_o,
  output logic [DATA_W-1:0] rdata_o,
  output logic [ADDR_W-1:0] addr_o,
  output logic              addr_vld_o,
  output logic [DATA_W-1:0] data_o,
  output logic              data_oe_o,
  input  logic [DATA_W-1:0] data_i,
  output logic              mem_rd_no,
  output logic              mem_wr_no,
  output logic              io_rd_no,
  output logic              io_wr_no
);
  tstate_e           state;
  logic              ready, start;
  logic [1:0]        kind;
  logic [N_STRB-1:0] strb_n;

  assign start = req_valid_i && ready;

  bus_seq_tstate i_tstate (
    .clk_i   (clk_i),
    .rst_ni  (rst_ni),
    .start_i (start),
    .state_o (state),
    .ready_o (ready),
    .done_o  (done_o)
  );

  bus_seq_dpath #(.ADDR_W(ADDR_W), .DATA_W(DATA_W)) i_dpath (
    .clk_i       (clk_i),
    .rst_ni      (rst_ni),
    .load_i      (start),
    .req_addr_i  (req_addr_i),
    .req_wdata_i (req_wdata_i),
    .req_kind_i  ({req_io_i, req_write_i}),
    .state_i     (state),
    .data_i      (data_i),
    .kind_o      (kind),
    .addr_o      (addr_o),
    .data_o      (data_o),
    .data_oe_o   (data_oe_o),
    .rdata_o     (rdata_o)
  );

  bus_seq_strobe i_strobe (
    .clk_i   (clk_i),
    .rst_ni  (rst_ni),
    .state_i (state),
    .kind_i  (kind),
    .strb_no (strb_n)
  );

  assign req_ready_o = ready;
  assign addr_vld_o  = (state == ST_T1);
  assign mem_rd_no   = strb_n[K_MEM_RD];
  assign mem_wr_no   = strb_n[K_MEM_WR];
  assign io_rd_no    = strb_n[K_IO_RD];
  assign io_wr_no    = strb_n[K_IO_WR];

  // R2
  accept_vld_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (req_valid_i && req_ready_o) |=> (addr_vld_o && !req_ready_o));
  // R6
  oe_with_wr_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    data_oe_o |-> (!mem_wr_no || !io_wr_no));
  // R5
  vld_no_strb_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    addr_vld_o |-> (mem_rd_no && mem_wr_no && io_rd_no && io_wr_no));
  // R8
  done_after_strb_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    done_o |-> (req_ready_o && mem_rd_no && mem_wr_no && io_rd_no && io_wr_no));
endmodule

// File: tb/test_bus_cycle_seq.sv
module test_bus_cycle_seq;
  localparam int AW = 20;
  localparam int DW = 8;

  logic          clk = 1'b0, rst_n = 1'b0;
  logic          req_valid = 1'b0, req_write = 1'b0, req_io = 1'b0;
  logic [AW-1:0] req_addr = '0;
  logic [DW-1:0] req_wdata = '0, data_in = '0;
  logic          req_ready, done, addr_vld, data_oe;
  logic [DW-1:0] rdata, data_out;
  logic [AW-1:0] addr;
  logic          mem_rd_n, mem_wr_n, io_rd_n, io_wr_n;

  int n_chk = 0, n_err = 0, cyc = 0;
  logic [DW-1:0] last_rd = '0;

  always #2.5 clk = ~clk;

  bus_cycle_seq i_bus_cycle_seq (
    .clk_i(clk), .rst_ni(rst_n),
    .req_valid_i(req_valid), .req_ready_o(req_ready),
    .req_write_i(req_write), .req_io_i(req_io),
    .req_addr_i(req_addr), .req_wdata_i(req_wdata),
    .done_o(done), .rdata_o(rdata),
    .addr_o(addr), .addr_vld_o(addr_vld),
    .data_o(data_out), .data_oe_o(data_oe), .data_i(data_in),
    .mem_rd_no(mem_rd_n), .mem_wr_no(mem_wr_n),
    .io_rd_no(io_rd_n), .io_wr_no(io_wr_n)
  );

  task automatic chk(input bit ok, input string req, input logic [31:0] act, input logic [31:0] exp);
    n_chk++;
    if (!ok) begin
      n_err++;
      $display("FAIL %s act=%h exp=%h", req, act, exp);
    end
  endtask

  function automatic logic [3:0] strbs();
    return {io_wr_n, io_rd_n, mem_wr_n, mem_rd_n};
  endfunction

  task automatic finish_run();
    $display("Result: errors=%0d of %0d checks", n_err, n_chk);
    $finish;
  endtask

  always @(posedge clk) begin
    cyc++;
    if (cyc > 150000) begin
      chk(1'b0, "watchdog", cyc, 150000);
      finish_run();
    end
  end

  // R5 continuous: at most one strobe low
  always @(negedge clk) if (rst_n)
    if ($countones(~strbs()) > 1) chk(1'b0, "R5 onehot", {28'd0, strbs()}, 32'hf);

  task automatic run_cycle(input logic [1:0] kind, input logic [AW-1:0] a, input logic [DW-1:0] d);
    logic [3:0] exp_strb;
    exp_strb = ~(4'b1 << kind);
    @(negedge clk);
    req_valid = 1'b1; req_io = kind[1]; req_write = kind[0];
    req_addr = a; req_wdata = d; data_in = ~d;
    chk(req_ready, "R2 ready idle", req_ready, 1);
    @(negedge clk); // T1
    req_valid = 1'b0;
    chk(addr_vld && addr == a, "R3 T1 addr", addr, a);
    chk(!req_ready, "R2 busy T1", req_ready, 0);
    chk(strbs() == 4'hf && !data_oe, "R5 T1 strobes", strbs(), 4'hf);
    data_in = d;
    @(negedge clk); // T2
    chk(strbs() == exp_strb, "R4 T2 strobe", strbs(), exp_strb);
    chk(!addr_vld && addr == a, "R3 T2 hold", {addr_vld, addr}, a);
    chk(data_oe == kind[0], "R6 T2 oe", data_oe, kind[0]);
    if (kind[0]) chk(data_out == d, "R6 T2 data", data_out, d);
    @(negedge clk); // T3
    chk(strbs() == exp_strb, "R4 T3 strobe", strbs(), exp_strb);
    chk(data_oe == kind[0] && !done, "R6 T3 oe", data_oe, kind[0]);
    @(negedge clk); // T4
    data_in = ~d; // late change must be ignored
    chk(strbs() == 4'hf && !data_oe, "R5 T4 strobes", strbs(), 4'hf);
    chk(!req_ready && !done && addr == a, "R8 T4 done low", done, 0);
    @(negedge clk); // after T4
    chk(done && req_ready, "R8 done pulse", done, 1);
    if (!kind[0]) last_rd = d;
    chk(rdata == last_rd, kind[0] ? "R8 write keeps rdata" : "R7 read capture", rdata, last_rd);
    @(negedge clk);
    chk(!done, "R8 done one clock", done, 0);
  endtask

  initial begin
    #1;
    @(negedge clk);
    chk(strbs() == 4'hf && !addr_vld && !data_oe && !done && req_ready, "R1 reset",
        {strbs(), addr_vld, data_oe, done, req_ready}, 32'hf1);
    rst_n = 1'b1;
    // R9 null cycles
    for (int i = 0; i < 6; i++) begin
      @(negedge clk);
      chk(strbs() == 4'hf && !addr_vld && req_ready && !done, "R9 null", strbs(), 4'hf);
    end
    // near-exhaustive sweep: kinds x address/data patterns
    for (int p = 0; p < 10; p++) begin
      for (int k = 0; k < 4; k++) begin
        logic [AW-1:0] a;
        logic [DW-1:0] d;
        a = (p < 5) ? AW'(20'h1 << (p * 4 + k)) : AW'(20'hfffff ^ (20'h1 << (p * 3 + k)));
        d = DW'(p * 37 + k * 91 + 5);
        run_cycle(2'(k), a, d);
      end
    end
    // R10 back-to-back with valid held
    begin
      int t_prev = -1;
      int gaps = 0;
      @(negedge clk);
      req_valid = 1'b1; req_io = 1'b1; req_write = 1'b0; req_addr = 20'habcde;
      for (int i = 0; i < 30; i++) begin
        @(negedge clk);
        if (addr_vld) begin
          if (t_prev >= 0) begin
            chk(cyc - t_prev == 5, "R10 spacing", cyc - t_prev, 5);
            gaps++;
          end
          t_prev = cyc;
        end
      end
      req_valid = 1'b0;
      chk(gaps >= 4, "R10 cycles seen", gaps, 4);
    end
    repeat (6) @(negedge clk);
    chk(strbs() == 4'hf && req_ready, "R9 idle after", strbs(), 4'hf);
    finish_run();
  end
endmodule